// File: doc/BRIEF.md
# Three-Tone Plus Noise Sound Generator

This block is a programmable sound source that the host can only write. It has three square-wave tone voices and one pseudo-random noise voice. Each voice has its own 4-bit attenuation, and the four voices are added into a single unsigned amplitude word. The host programs the block one byte at a time through an 8-bit port with a write strobe. Changing a full tone period takes two bytes: a command byte that selects the target register and gives the low four bits, then a data byte that gives the upper six bits.

All voices advance on a shared timebase of the input clock divided by 16. The noise voice can shift at one of three fixed rates. It can also be tied to the third tone voice, so that its pitch follows that voice's divider. A later stage turns the output word into sound. There is no envelope logic and no read path.

Top module: `psg_core`

## Requirements
- R1: After reset all four attenuations are 15, all tone periods are 0, and the noise control is 0 (periodic, rate 0). `mix_out` stays 0 until the host writes.
- R2: A byte with bit 7 set is a command byte. Bits 6:5 select the channel (0 to 2 are tones, 3 is noise). Bit 4 selects attenuation (1) or period/noise control (0). Bits 3:0 are the data. An attenuation command sets that channel's attenuation. A tone period command replaces bits 3:0 of that tone's 10-bit period and keeps bits 9:4. The command also becomes the latched target.
- R3: A byte with bit 7 clear writes bits 5:0 into period bits 9:4 of the latched tone, but only when the latched target is a tone period. When the latched target is an attenuation or the noise control, the byte has no effect.
- R4: A tone output flips each time its counter expires on the divide-by-16 tick, and then reloads the period P. Each half cycle lasts 16·P clocks, so the full cycle is 32·P clocks. P = 0 behaves like P = 1.
- R5: Attenuation a gives level L(a). L(0) = 2^10 − 1. L(a) = floor(L(a−1)·203/256) for a = 1 to 14, which is about 2 dB per step. L(15) = 0.
- R6: `mix_out` is the sum of L(att) over every channel whose output is currently high. The noise output is LFSR bit 0.
- R7: The noise source is a 15-bit register that shifts right. The new bit 14 is bit0 XOR bit1 in white mode (control bit 2 = 1) and bit 0 alone in periodic mode (control bit 2 = 0). The register never holds zero.
- R8: When control bits 1:0 hold r < 3, the noise register shifts once every 16·2^r ticks. When r = 3, it shifts on each rising edge of tone channel 2's output.
- R9: Any noise control command (byte 0xE0 to 0xE7) reloads the register with 0x4000 and restarts the rate counter. Periodic mode therefore gives one high shift in every 15 shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one byte per high cycle |
| wr_data | input | 8 | Command or data byte |
| mix_out | output | 12 | Sum of the active channel levels |

## Verification
On every cycle, the assertions check four things. Attenuation commands land in the addressed channel. Tone outputs change only on a prescaler tick. The noise register is never zero and holds the seed right after a noise control write. The mix is zero whenever every channel is muted. Only the bench scenarios can show the cycle-level results: the rise-to-rise periods of each tone, the full level table, ignored data bytes, the periodic and white noise bit streams, and noise paced by tone channel 2. The bench measures all of these from `mix_out`.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int NUM_TONES = 3;
  localparam int NUM_CH    = NUM_TONES + 1;
  localparam int ATT_W     = 4;
  localparam int LFSR_W    = 15;
  localparam logic [LFSR_W-1:0] LFSR_SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  typedef struct packed {
    logic       white;
    logic [1:0] rate;
  } noise_ctl_t;

  // Level for attenuation step att: ~2 dB per step, last step mutes.
  function automatic int level_of(input int att, input int full);
    int v;
    v = full;
    if (att >= (1 << ATT_W) - 1) return 0;
    for (int i = 0; i < att; i++) v = (v * 203) / 256;
    return v;
  endfunction
endpackage

// File: rtl/psg_regs.sv
module psg_regs
  import psg_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [7:0]                        wr_data,
  output logic [NUM_TONES-1:0][PW-1:0]      period_o,
  output logic [NUM_CH-1:0][ATT_W-1:0]      att_o,
  output noise_ctl_t                        nctl_o,
  output logic                              reseed_o
);
  localparam int HI_W = PW - 4;

  logic [1:0]                         lat_ch_q, lat_ch_d;
  logic                               lat_vol_q, lat_vol_d;
  logic [NUM_TONES-1:0][PW-1:0]       per_q, per_d;
  logic [NUM_CH-1:0][ATT_W-1:0]       att_q, att_d;
  noise_ctl_t                         nctl_q, nctl_d;
  logic                               reseed;

  always_comb begin
    lat_ch_d  = lat_ch_q;
    lat_vol_d = lat_vol_q;
    per_d     = per_q;
    att_d     = att_q;
    nctl_d    = nctl_q;
    reseed    = 1'b0;
    if (wr_en) begin
      if (wr_data[7]) begin
        lat_ch_d  = wr_data[6:5];
        lat_vol_d = wr_data[4];
        if (wr_data[4]) begin
          att_d[wr_data[6:5]] = wr_data[ATT_W-1:0];
        end else if (int'(wr_data[6:5]) == NUM_TONES) begin
          nctl_d = noise_ctl_t'(wr_data[2:0]);
          reseed = 1'b1;
        end else begin
          per_d[wr_data[6:5]][3:0] = wr_data[3:0];
        end
      end else if (!lat_vol_q && int'(lat_ch_q) < NUM_TONES) begin
        per_d[lat_ch_q][PW-1:4] = wr_data[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_ch_q  <= '0;
      lat_vol_q <= 1'b0;
      per_q     <= '0;
      att_q     <= '1;
      nctl_q    <= '0;
    end else begin
      lat_ch_q  <= lat_ch_d;
      lat_vol_q <= lat_vol_d;
      per_q     <= per_d;
      att_q     <= att_d;
      nctl_q    <= nctl_d;
    end
  end

  assign period_o = per_q;
  assign att_o    = att_q;
  assign nctl_o   = nctl_q;
  assign reseed_o = reseed;
endmodule

// File: rtl/psg_tone.sv
module psg_tone #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          tone_o
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (tick) begin
      if (cnt_q <= PW'(1)) begin
        out_d = ~out_q;
        cnt_d = period;
      end else begin
        cnt_d = cnt_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign tone_o = out_q;
endmodule

// File: rtl/psg_noise.sv
module psg_noise
  import psg_pkg::*;
#(
  parameter int NOISE_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  noise_ctl_t        ctl,
  input  logic              reseed,
  input  logic              sync_in,
  output logic              noise_o,
  output logic [LFSR_W-1:0] lfsr_o
);
  localparam int CW = $clog2(NOISE_BASE * 4) + 1;

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [CW-1:0]     cnt_q, cnt_d, lim;
  logic              sync_q;
  logic              shift_en, fb;

  always_comb begin
    lim      = CW'(NOISE_BASE) << ctl.rate;
    fb       = ctl.white ? (lfsr_q[0] ^ lfsr_q[1]) : lfsr_q[0];
    cnt_d    = cnt_q;
    shift_en = 1'b0;
    if (ctl.rate == 2'd3) begin
      shift_en = sync_in & ~sync_q;
    end else if (tick) begin
      if (cnt_q >= lim - CW'(1)) begin
        shift_en = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    lfsr_d = shift_en ? {fb, lfsr_q[LFSR_W-1:1]} : lfsr_q;
    if (reseed) begin
      lfsr_d = LFSR_SEED;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      lfsr_q <= lfsr_d;
      cnt_q  <= cnt_d;
      sync_q <= sync_in;
    end
  end

  assign noise_o = lfsr_q[0];
  assign lfsr_o  = lfsr_q;
endmodule

// File: rtl/psg_core.sv
module psg_core
  import psg_pkg::*;
#(
  parameter int PRESCALE   = 16,
  parameter int PW         = 10,
  parameter int AMP_W      = 10,
  parameter int NOISE_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [AMP_W+1:0] mix_out
);
  localparam int PSW   = $clog2(PRESCALE);
  localparam int OW    = AMP_W + 2;
  localparam int FULL  = (1 << AMP_W) - 1;
  localparam int STEPS = 1 << ATT_W;

  logic [1:0]                    rst_sync_q;
  logic                          rst_sn;
  logic [PSW-1:0]                pre_q, pre_d;
  logic                          tick_w;
  logic [NUM_TONES-1:0][PW-1:0]  period_w;
  logic [NUM_CH-1:0][ATT_W-1:0]  att_w;
  noise_ctl_t                    nctl_w;
  logic                          reseed_w;
  logic [NUM_TONES-1:0]          tone_w;
  logic                          noise_w;
  logic [LFSR_W-1:0]             lfsr_w;
  logic [NUM_CH-1:0]             chan_hi;
  logic [AMP_W-1:0]              lvl_tab [STEPS];
  logic [OW-1:0]                 sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign tick_w = (pre_q == PSW'(PRESCALE - 1));
  always_comb pre_d = tick_w ? '0 : pre_q + PSW'(1);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  psg_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_data(wr_data),
    .period_o(period_w), .att_o(att_w), .nctl_o(nctl_w), .reseed_o(reseed_w)
  );

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
    psg_tone #(.PW(PW)) u_tone (
      .clk(clk), .rst_n(rst_sn), .tick(tick_w),
      .period(period_w[t]), .tone_o(tone_w[t])
    );
  end

  psg_noise #(.NOISE_BASE(NOISE_BASE)) u_noise (
    .clk(clk), .rst_n(rst_sn), .tick(tick_w), .ctl(nctl_w),
    .reseed(reseed_w), .sync_in(tone_w[NUM_TONES-1]),
    .noise_o(noise_w), .lfsr_o(lfsr_w)
  );

  for (genvar s = 0; s < STEPS; s++) begin : g_lvl
    assign lvl_tab[s] = AMP_W'(level_of(s, FULL));
  end

  assign chan_hi = {noise_w, tone_w};

  always_comb begin
    sum = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_hi[c]) sum = sum + OW'(lvl_tab[att_w[c]]);
    end
  end

  assign mix_out = sum;
endmodule

// File: rtl/psg_chk.sv
module psg_chk
  import psg_pkg::*;
#(
  parameter int AMP_W = 10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [7:0]                   wr_data,
  input logic [NUM_CH-1:0][ATT_W-1:0] att,
  input logic [NUM_TONES-1:0]         tone,
  input logic                         tick,
  input logic [LFSR_W-1:0]            lfsr,
  input logic [AMP_W+1:0]             mix_out
);
  AST_VOL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && wr_data[4]) |=> (att[$past(wr_data[6:5])] == $past(wr_data[3:0]))); // R2

  AST_TONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tone != $past(tone)) |-> $past(tick)); // R4

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr != '0)); // R7

  AST_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:4] == 4'hE) |=> (lfsr == LFSR_SEED)); // R9

  AST_SILENT_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (&att) |-> (mix_out == '0)); // R5
endmodule

bind psg_core psg_chk #(.AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_data(wr_data),
  .att(att_w), .tone(tone_w), .tick(tick_w), .lfsr(lfsr_w), .mix_out(mix_out)
);

// File: tb/tb_psg_core.sv
module tb_psg_core;
  localparam int AMP_W = 10;
  localparam int OW    = AMP_W + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic [OW-1:0] mix_out;
  int            errors = 0;
  int            checks = 0;

  always #10 clk = ~clk;

  psg_core dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mix_out(mix_out));

  function automatic int lvl(input int a);
    int v;
    v = (1 << AMP_W) - 1;
    if (a >= 15) return 0;
    for (int i = 0; i < a; i++) v = (v * 203) / 256;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_data = b; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    while (mix_out != 0) @(negedge clk);
    while (mix_out == 0) @(negedge clk);
  endtask

  // Rise-to-rise gap and high time, in clocks.
  task automatic rise_gap(output int gap, output int high);
    wait_rise();
    gap = 0; high = 0;
    while (mix_out != 0) begin @(negedge clk); gap++; high++; end
    while (mix_out == 0) begin @(negedge clk); gap++; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int g, h, bad, m;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: silent after reset
    bad = 0;
    repeat (400) begin @(negedge clk); if (mix_out != 0) bad++; end
    check("R1 reset silent", bad, 0);

    // R5 sweep of every attenuation on tone 0 while it is high
    wr(8'h80); wr(8'h10); wr(8'h90);
    wait_rise();
    for (int a = 0; a < 16; a++) begin
      wr(8'h90 | 8'(a));
      check($sformatf("R5 level att=%0d", a), int'(mix_out), lvl(a));
    end
    // R3: data byte with attenuation latched is ignored
    wr(8'h93); wr(8'h2A);
    check("R3 ignored data level", int'(mix_out), lvl(3));
    wr(8'h90);
    rise_gap(g, h);
    check("R3 ignored data period", g, 32 * 256);

    // R4 / R2 / R3: tone periods
    wr(8'h81); wr(8'h00); rise_gap(g, h); check("R4 P=1", g, 32);
    check("R4 P=1 half", h, 16);
    wr(8'h80); rise_gap(g, h); check("R4 P=0 acts as 1", g, 32);
    wr(8'h87); rise_gap(g, h); check("R4 P=7", g, 224);
    wr(8'h83); wr(8'h01); rise_gap(g, h); check("R3 P=0x13", g, 32 * 19);
    wr(8'h85); rise_gap(g, h); check("R2 low nibble keeps high", g, 32 * 21);
    wr(8'h84); wr(8'h06); rise_gap(g, h); check("R4 P=100", g, 3200);
    wr(8'h9F);
    wr(8'hAA); wr(8'h02); wr(8'hB0); rise_gap(g, h); check("R4 ch1 P=42", g, 32 * 42);
    wr(8'hBF);
    wr(8'hC9); wr(8'h00); wr(8'hD0); rise_gap(g, h); check("R4 ch2 P=9", g, 288);
    wr(8'hDF);

    // R6 mix of two tones
    wr(8'h83); wr(8'h00); wr(8'h90);
    wr(8'hA5); wr(8'h00); wr(8'hB4);
    repeat (2000) @(negedge clk);
    bad = 0; seen = 1'b0;
    repeat (3000) begin
      @(negedge clk);
      if (!(mix_out == 0 || int'(mix_out) == lvl(0) || int'(mix_out) == lvl(4) ||
            int'(mix_out) == lvl(0) + lvl(4))) bad++;
      if (int'(mix_out) == lvl(0) + lvl(4)) seen = 1'b1;
    end
    check("R6 mix values", bad, 0);
    check("R6 sum observed", int'(seen), 1);
    wr(8'h9F); wr(8'hBF); wr(8'hDF);

    // R8 / R9 periodic noise, rate 0
    wr(8'hF0); wr(8'hE0);
    rise_gap(g, h);
    check("R9 periodic gap", g, 15 * 256);
    check("R8 periodic high", h, 256);
    wait_rise(); wr(8'hE0);
    check("R9 reseed clears output", int'(mix_out), 0);

    // R7 white noise stream
    wr(8'hE4);
    m = 32'h4000;
    while ((m & 1) == 0) m = (m >> 1) | (((m ^ (m >> 1)) & 1) << 14);
    wait_rise();
    repeat (128) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      check($sformatf("R7 white bit %0d", k), int'(mix_out != 0), m & 1);
      m = (m >> 1) | (((m ^ (m >> 1)) & 1) << 14);
      repeat (256) @(negedge clk);
    end

    // R8 noise paced by tone 2 rising edges
    wr(8'hC2); wr(8'h00); wr(8'hDF); wr(8'hE3);
    rise_gap(g, h);
    check("R8 sync gap", g, 15 * 64);
    check("R8 sync high", h, 64);

    summary();
    $finish;
  end
endmodule